// File: doc/BRIEF.md
# Bus Activity Capture Sniffer

This block watches an 8-bit expansion bus without taking part in it. Every clock of the processor it sees a vector of bus signals and the processor's two prefetch-queue status lines. All of these are inputs only: the block has no path that drives or loads a bus line. A host arms the block with a one-cycle strobe. The first cycle after that in which the trigger condition is high becomes sample zero. The block then records a fixed number of consecutive cycles into an on-chip buffer.

Each sample is one word. The bus bits sit at the bottom of the word. Above them is a 2-bit queue-operation code, decoded from the raw status pins. When the buffer is full, the block sends its contents to another computer over a slow serial line. It sends a header byte first, then every word in capture order. Each word goes out as bytes, least significant byte first. A busy flag covers the whole time from arming to the end of the last stop bit. The block ignores a new arm or trigger until that time is over.

Top module: `bus_capture_sniffer`

## Requirements
- R1: While reset is applied and after it, before any arm, the serial line idles high (1) and busy is low.
- R2: An arm pulse while idle raises busy on the next cycle. A trigger while idle and not armed is ignored: busy stays low and the serial line stays high.
- R3: Once armed, the first cycle with the trigger high is stored as word 0. The DEPTH cycles that follow it in a row, including the trigger cycle, fill words 0 to DEPTH-1.
- R4: Each word holds the bus vector in bits [13:0]. Bits [15:14] hold the queue code, mapped from the raw status pins {qs[1],qs[0]} as 00->0 (no change), 01->1 (first opcode byte), 11->2 (later opcode byte), 10->3 (queue flushed).
- R5: The transmission is the header byte 0xA5, then words 0 to DEPTH-1 in order. Each word is sent as its low byte [7:0] and then its high byte [15:8]. Exactly 2*DEPTH+1 bytes are sent per run.
- R6: Each byte is framed 8N1: one start bit at 0, eight data bits with the least significant bit first, and one stop bit at 1. Each bit lasts CLKS_PER_BIT clocks.
- R7: While a capture or transmission is in progress, arm and trigger pulses have no effect: no second run starts and no extra byte is sent.
- R8: Busy stays high through the stop bit of the last byte. It falls no more than two clocks after that stop bit ends.
- R9: After a run the block goes back to idle, and it needs a new arm before any trigger can start another capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, one edge per processor cycle |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_i | input | BUS_W | Bus signal vector to sample |
| qs_i | input | 2 | Raw prefetch-queue status pins |
| arm_i | input | 1 | One-cycle arm strobe, accepted only when idle |
| trig_i | input | 1 | Trigger condition, acted on only when armed |
| uart_tx_o | output | 1 | Serial transmit line, idle high |
| busy_o | output | 1 | High from arm until the last stop bit has been sent |

## Verification
A fill counter or buffer address that is off by one shows up in the serial stream as a shift of words, one sample later than expected. It can also show up as a wrong byte count, seen as soon as the last byte arrives. A state machine that accepts an arm or trigger when it should not shows up as extra bytes, or as busy staying high, tens of clocks after the expected end. A wrong queue-code mapping or byte order is visible in the first data byte that carries that pattern. The serial framing is checked bit by bit, at the centre of every bit.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

  typedef enum logic [1:0] {
    CAP_IDLE  = 2'd0,
    CAP_ARMED = 2'd1,
    CAP_FILL  = 2'd2,
    CAP_SEND  = 2'd3
  } cap_state_e;

  typedef enum logic [1:0] {
    QOP_NONE  = 2'd0,
    QOP_FIRST = 2'd1,
    QOP_NEXT  = 2'd2,
    QOP_FLUSH = 2'd3
  } qop_e;

  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_START = 2'd1,
    TX_DATA  = 2'd2,
    TX_STOP  = 2'd3
  } tx_state_e;

  localparam logic [7:0] FRAME_HEADER = 8'hA5;
  localparam int QS_W = 2;

endpackage

// File: rtl/bcs_qs_decode.sv
module bcs_qs_decode
  import bcs_pkg::*;
(
  input  logic [1:0] qs_raw_i,
  output qop_e       op_o
);

  always_comb begin
    unique case (qs_raw_i)
      2'b00:   op_o = QOP_NONE;
      2'b01:   op_o = QOP_FIRST;
      2'b11:   op_o = QOP_NEXT;
      default: op_o = QOP_FLUSH;
    endcase
  end

endmodule

// File: rtl/bcs_sample_ram.sv
module bcs_sample_ram #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rdata_o
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) begin
      mem[waddr_i] <= wdata_i;
    end
  end

  always_ff @(posedge clk) begin
    rdata_o <= mem[raddr_i];
  end

endmodule

// File: rtl/bcs_uart_tx.sv
module bcs_uart_tx
  import bcs_pkg::*;
#(
  parameter int CLKS_PER_BIT = 41,
  localparam int CW = (CLKS_PER_BIT > 2) ? $clog2(CLKS_PER_BIT) : 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [7:0] data_i,
  output logic       ready_o,
  output logic       tx_o
);

  localparam logic [CW-1:0] RELOAD = CW'(CLKS_PER_BIT - 1);

  tx_state_e     state_q, state_d;
  logic [CW-1:0] baud_q, baud_d;
  logic [2:0]    bit_q, bit_d;
  logic [7:0]    shr_q, shr_d;
  logic          tick;

  assign tick = (baud_q == '0);

  always_comb begin
    state_d = state_q;
    baud_d  = baud_q;
    bit_d   = bit_q;
    shr_d   = shr_q;
    unique case (state_q)
      TX_IDLE: begin
        if (start_i) begin
          state_d = TX_START;
          baud_d  = RELOAD;
          shr_d   = data_i;
        end
      end
      TX_START: begin
        if (tick) begin
          state_d = TX_DATA;
          baud_d  = RELOAD;
          bit_d   = 3'd0;
        end else begin
          baud_d = baud_q - 1'b1;
        end
      end
      TX_DATA: begin
        if (tick) begin
          baud_d = RELOAD;
          shr_d  = {1'b0, shr_q[7:1]};
          if (bit_q == 3'd7) begin
            state_d = TX_STOP;
          end else begin
            bit_d = bit_q + 1'b1;
          end
        end else begin
          baud_d = baud_q - 1'b1;
        end
      end
      default: begin
        if (tick) begin
          state_d = TX_IDLE;
        end else begin
          baud_d = baud_q - 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      baud_q  <= '0;
      bit_q   <= '0;
      shr_q   <= '0;
    end else begin
      state_q <= state_d;
      baud_q  <= baud_d;
      bit_q   <= bit_d;
      shr_q   <= shr_d;
    end
  end

  always_comb begin
    unique case (state_q)
      TX_START: tx_o = 1'b0;
      TX_DATA:  tx_o = shr_q[0];
      default:  tx_o = 1'b1;
    endcase
  end

  assign ready_o = (state_q == TX_IDLE);

  // R6: an accepted byte opens with a low start bit
  a_r6_start_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && ready_o) |=> (tx_o == 1'b0));

  // R6: the line holds its level for the whole bit period
  a_r6_bit_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != TX_IDLE && !tick) |=> $stable(tx_o));

  // R6: the frame ends with a high stop bit before returning to idle
  a_r6_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != TX_IDLE && state_d == TX_IDLE) |-> (tx_o == 1'b1));

endmodule

// File: rtl/bus_capture_sniffer.sv
module bus_capture_sniffer
  import bcs_pkg::*;
#(
  parameter int BUS_W        = 14,
  parameter int DEPTH        = 1024,
  parameter int CLKS_PER_BIT = 41
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BUS_W-1:0] bus_i,
  input  logic [1:0]       qs_i,
  input  logic             arm_i,
  input  logic             trig_i,
  output logic             uart_tx_o,
  output logic             busy_o
);

  localparam int WORD_W = BUS_W + QS_W;
  localparam int BPW    = (WORD_W + 7) / 8;
  localparam int WIDE_W = BPW * 8;
  localparam int BSW    = (BPW > 1) ? $clog2(BPW) : 1;
  localparam int AW     = $clog2(DEPTH);
  localparam logic [AW-1:0]  LAST_ADDR = AW'(DEPTH - 1);
  localparam logic [BSW-1:0] LAST_BYTE = BSW'(BPW - 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_pipe_q[1];

  // sample word: queue code above the bus bits
  qop_e              qop;
  logic [WORD_W-1:0] sample_word;

  bcs_qs_decode i_qs_decode (
    .qs_raw_i (qs_i),
    .op_o     (qop)
  );

  assign sample_word = {logic'(qop[1]), logic'(qop[0]), bus_i};

  // control state
  cap_state_e     state_q, state_d;
  logic [AW-1:0]  wr_cnt_q, wr_cnt_d;
  logic [AW-1:0]  word_q, word_d;
  logic [BSW-1:0] bsel_q, bsel_d;
  logic           hdr_q, hdr_d;
  logic           done_q, done_d;

  logic              ram_we;
  logic [AW-1:0]     ram_waddr;
  logic [WORD_W-1:0] rd_word;
  logic [WIDE_W-1:0] rd_wide;
  logic              tx_start;
  logic [7:0]        tx_byte;
  logic              tx_ready;

  assign rd_wide = WIDE_W'(rd_word);

  always_comb begin
    state_d  = state_q;
    wr_cnt_d = wr_cnt_q;
    word_d   = word_q;
    bsel_d   = bsel_q;
    hdr_d    = hdr_q;
    done_d   = done_q;
    ram_we   = 1'b0;
    tx_start = 1'b0;
    tx_byte  = 8'h00;
    unique case (state_q)
      CAP_IDLE: begin
        if (arm_i) begin
          state_d = CAP_ARMED;
        end
      end
      CAP_ARMED: begin
        if (trig_i) begin
          ram_we   = 1'b1;
          wr_cnt_d = AW'(1);
          word_d   = '0;
          bsel_d   = '0;
          hdr_d    = 1'b0;
          done_d   = 1'b0;
          state_d  = CAP_FILL;
        end
      end
      CAP_FILL: begin
        ram_we = 1'b1;
        if (wr_cnt_q == LAST_ADDR) begin
          state_d = CAP_SEND;
        end else begin
          wr_cnt_d = wr_cnt_q + 1'b1;
        end
      end
      default: begin
        if (tx_ready) begin
          if (done_q) begin
            state_d = CAP_IDLE;
          end else begin
            tx_start = 1'b1;
            if (!hdr_q) begin
              tx_byte = FRAME_HEADER;
              hdr_d   = 1'b1;
            end else begin
              tx_byte = rd_wide[{bsel_q, 3'b000} +: 8];
              if (bsel_q == LAST_BYTE) begin
                bsel_d = '0;
                if (word_q == LAST_ADDR) begin
                  done_d = 1'b1;
                end else begin
                  word_d = word_q + 1'b1;
                end
              end else begin
                bsel_d = bsel_q + 1'b1;
              end
            end
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q  <= CAP_IDLE;
      wr_cnt_q <= '0;
      word_q   <= '0;
      bsel_q   <= '0;
      hdr_q    <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      wr_cnt_q <= wr_cnt_d;
      word_q   <= word_d;
      bsel_q   <= bsel_d;
      hdr_q    <= hdr_d;
      done_q   <= done_d;
    end
  end

  assign ram_waddr = (state_q == CAP_ARMED) ? '0 : wr_cnt_q;

  bcs_sample_ram #(
    .WIDTH (WORD_W),
    .DEPTH (DEPTH)
  ) i_sample_ram (
    .clk     (clk),
    .we_i    (ram_we),
    .waddr_i (ram_waddr),
    .wdata_i (sample_word),
    .raddr_i (word_q),
    .rdata_o (rd_word)
  );

  bcs_uart_tx #(
    .CLKS_PER_BIT (CLKS_PER_BIT)
  ) i_uart_tx (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .start_i (tx_start),
    .data_i  (tx_byte),
    .ready_o (tx_ready),
    .tx_o    (uart_tx_o)
  );

  assign busy_o = (state_q != CAP_IDLE);

  // R2: without an arm the block stays idle whatever the trigger does
  a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state_q == CAP_IDLE && !arm_i) |=> (state_q == CAP_IDLE));

  // R3: the fill runs until the last buffer slot is written, then sending starts
  a_r3_fill_continues: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state_q == CAP_FILL && wr_cnt_q != LAST_ADDR) |=> (state_q == CAP_FILL));
  a_r3_fill_ends: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state_q == CAP_FILL && wr_cnt_q == LAST_ADDR) |=> (state_q == CAP_SEND));

  // R7: capture or send never falls back to the armed state
  a_r7_no_rearm: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state_q == CAP_FILL || state_q == CAP_SEND) |=> (state_q != CAP_ARMED));

  // R8: busy holds while the transmitter still has a byte on the line
  a_r8_busy_while_tx: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state_q == CAP_SEND && !tx_ready) |=> busy_o);

endmodule

// File: tb/test_bus_capture_sniffer.sv
module test_bus_capture_sniffer;

  localparam int BUS_W = 14;
  localparam int DEPTH = 8;
  localparam int CPB   = 4;
  localparam int NBYTE = 2 * DEPTH + 1;

  logic             clk;
  logic             rst_n;
  logic [BUS_W-1:0] bus;
  logic [1:0]       qs;
  logic             arm;
  logic             trig;
  logic             uart_tx;
  logic             busy;

  int checks;
  int errors;

  logic [7:0]  rx_buf [64];
  int          rx_cnt;
  logic        rx_en;
  logic [7:0]  rx_byte;
  logic [15:0] exp_words [DEPTH];

  bus_capture_sniffer #(
    .BUS_W        (BUS_W),
    .DEPTH        (DEPTH),
    .CLKS_PER_BIT (CPB)
  ) i_bus_capture_sniffer (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_i     (bus),
    .qs_i      (qs),
    .arm_i     (arm),
    .trig_i    (trig),
    .uart_tx_o (uart_tx),
    .busy_o    (busy)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [1:0] qcode(input logic [1:0] raw);
    case (raw)
      2'b00:   return 2'd0;
      2'b01:   return 2'd1;
      2'b11:   return 2'd2;
      default: return 2'd3;
    endcase
  endfunction

  function automatic logic [15:0] exp_word(input logic [BUS_W-1:0] b, input logic [1:0] q);
    return {qcode(q), b};
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // serial receiver: samples each bit in its centre
  always begin
    @(negedge clk);
    if (rx_en && uart_tx === 1'b0) begin
      repeat (2) @(negedge clk);
      for (int b = 0; b < 8; b++) begin
        repeat (CPB) @(negedge clk);
        rx_byte[b] = uart_tx;
      end
      repeat (CPB) @(negedge clk);
      check("R6", "stop bit", {31'd0, uart_tx}, 32'd1);
      if (rx_cnt < 64) rx_buf[rx_cnt] = rx_byte;
      rx_cnt++;
    end
  end

  task automatic run_capture(input int mode, input int pre_idle);
    logic [BUS_W-1:0] b;
    logic [1:0]       q;
    rx_cnt = 0;
    @(negedge clk);
    arm = 1'b1;
    @(negedge clk);
    arm = 1'b0;
    check("R2", "busy after arm", {31'd0, busy}, 32'd1);
    for (int i = 0; i < pre_idle; i++) begin
      bus = BUS_W'($urandom);
      qs  = 2'($urandom);
      @(negedge clk);
    end
    for (int k = 0; k < DEPTH; k++) begin
      if (mode == 1) begin
        b = (k % 2 == 0) ? '1 : '0;
        q = 2'(k);
      end else begin
        b = BUS_W'($urandom);
        q = 2'($urandom);
      end
      bus  = b;
      qs   = q;
      trig = (k == 0) ? 1'b1 : 1'($urandom);
      arm  = (k == 0) ? 1'b0 : ($urandom % 3 == 0);
      exp_words[k] = exp_word(b, q);
      @(negedge clk);
    end
    arm = 1'b0;
    // R7: trigger pulses while sending
    while (rx_cnt < NBYTE) begin
      trig = ($urandom % 4 == 0);
      bus  = BUS_W'($urandom);
      @(negedge clk);
      if (!busy) break;
    end
    trig = 1'b0;
    wait (rx_cnt >= NBYTE);
    check("R8", "busy at last stop bit", {31'd0, busy}, 32'd1);
    repeat (4) @(negedge clk);
    check("R8", "busy after last stop bit", {31'd0, busy}, 32'd0);
    check("R5", "byte count", rx_cnt, NBYTE);
    check("R5", "header byte", {24'd0, rx_buf[0]}, 32'hA5);
    for (int k = 0; k < DEPTH; k++) begin
      check((k == 0) ? "R3" : "R4", "word low byte", {24'd0, rx_buf[2*k+1]},
            {24'd0, exp_words[k][7:0]});
      check("R5", "word high byte", {24'd0, rx_buf[2*k+2]},
            {24'd0, exp_words[k][15:8]});
    end
    repeat (60) @(negedge clk);
    check("R7", "no extra bytes", rx_cnt, NBYTE);
    check("R9", "idle after run", {31'd0, busy}, 32'd0);
  endtask

  initial begin : main
    void'($urandom(32'd2024));
    checks = 0;
    errors = 0;
    rx_cnt = 0;
    rx_en  = 1'b0;
    rst_n  = 1'b0;
    bus    = '0;
    qs     = '0;
    arm    = 1'b0;
    trig   = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "tx in reset", {31'd0, uart_tx}, 32'd1);
    check("R1", "busy in reset", {31'd0, busy}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rx_en = 1'b1;
    check("R1", "tx after reset", {31'd0, uart_tx}, 32'd1);
    check("R1", "busy after reset", {31'd0, busy}, 32'd0);

    // R2: trigger alone is ignored
    for (int i = 0; i < 6; i++) begin
      trig = 1'b1;
      bus  = BUS_W'($urandom);
      @(negedge clk);
      check("R2", "busy on bare trigger", {31'd0, busy}, 32'd0);
      check("R2", "tx on bare trigger", {31'd0, uart_tx}, 32'd1);
    end
    trig = 1'b0;

    run_capture(1, 0);
    run_capture(0, 3);
    // R9: after a run a trigger without arm does nothing
    trig = 1'b1;
    repeat (5) @(negedge clk);
    trig = 1'b0;
    check("R9", "no run without re-arm", {31'd0, busy}, 32'd0);
    run_capture(0, 1);
    run_capture(0, 5);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : watchdog
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: run did not complete, actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule